// File: doc/BRIEF.md
# Multi-Column Read Cache

A four-way set-associative read cache in which every block has a fixed home way inside its set. The home way is the low tag bits just above the set index. Blocks that share a set and a home way form a group. The group's most recently used block is always kept in the home way. A first probe reads only that way, so a hit there costs the same as a hit in a direct-mapped cache.

The group's older blocks are held in other ways of the same set. A per-home bit vector records which ways they occupy. When the first probe misses, the cache probes those ways one per cycle, starting at the lowest way index. A hit in one of them swaps that block with the block in the home way.

When every probe misses, the cache fetches one block from memory through a request/acknowledge handshake. The fetched block goes into the home way. The block it replaces is moved to another way of the set or dropped. Each response reports one of three outcomes: first hit, later hit or miss.

Top module: `mc_cache`

## Requirements
- R1: After reset, every entry is invalid and every bit vector is empty, so the first access to any address is a miss. While idle, `req_ready_o` is 1, and `resp_valid_o` and `mem_req_o` are 0.
- R2: The address is split as {tag, set}, and the home way is tag[1:0]. A request whose block sits in its home way gets status 0 (first hit) with the stored data. The response comes two cycles after the request is accepted.
- R3: The block just fetched or just hit is always found in its home way. The next access to it is a first hit.
- R4: On a miss, `mem_addr_o` equals the request address. The response carries `mem_data_i` with status 2 (miss), and the fetched block is written into the home way.
- R5: A hit on a block outside its home way returns status 1 (later hit) with that block's data. That block and the home way's block trade places.
- R6: After a first-probe miss, the ways listed in the home's bit vector are probed in ascending way order, one way per cycle. A hit at the n-th listed way responds 2+n cycles after acceptance.
- R7: If the home way holds an older block of a different group, a fill overwrites it and clears that group's vector bit. A later access to the overwritten block is a miss, never a false hit.
- R8: When a fill displaces its own group's previous block, the block moves to a new way, and that way's bit is set in the group's vector. The new way is chosen in this order:
  - the lowest-indexed invalid way other than the home way;
  - otherwise the lowest-indexed way holding some group's older block, whose owner's bit is then cleared;
  - otherwise the block is dropped.
- R9: `req_ready_o` is 1 only when idle. `resp_valid_o` is a one-cycle pulse. `mem_req_o` stays high with a stable address until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_addr_i | input | ADDR_W | Block address {tag, set} |
| resp_valid_o | output | 1 | Response pulse |
| resp_status_o | output | 2 | 0 first hit, 1 later hit, 2 miss |
| resp_data_o | output | DATA_W | Read data |
| mem_req_o | output | 1 | Block fetch request |
| mem_addr_o | output | ADDR_W | Fetch block address |
| mem_ack_i | input | 1 | Fetch data valid this cycle |
| mem_data_i | input | DATA_W | Fetched block |

## Verification
A wrong bit vector shows at the ports as a miss where a later hit was due. It can also show as a later hit that arrives in the wrong cycle, because the search order sets the latency. A missing swap shows on the very next access to that block, as status 1 where status 0 was due. A placement error stays hidden until a later access reaches the displaced or overwritten block. For that reason the scenarios chain many dependent accesses in the same set.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_SCAN  = 2'd2,
    ST_FILL  = 2'd3
  } mc_state_e;

  typedef enum logic [1:0] {
    MC_FIRST = 2'd0,
    MC_NEXT  = 2'd1,
    MC_MISS  = 2'd2
  } mc_status_e;
endpackage

// File: rtl/mc_first_one.sv
module mc_first_one #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mc_place_pick.sv
module mc_place_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][WAY_W-1:0]  owner_i,
  input  logic [WAY_W-1:0]            excl_i,
  output logic                        found_o,
  output logic [WAY_W-1:0]            way_o,
  output logic                        is_sel_o
);
  logic [WAYS-1:0]  empty_v, sel_v;
  logic             e_found, s_found;
  logic [WAY_W-1:0] e_idx, s_idx;

  for (genvar w = 0; w < WAYS; w++) begin : g_cls
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);
    assign empty_v[w] = !vld_i[w] && (excl_i != WID);
    // older block: valid and not sitting in its own home way
    assign sel_v[w]   = vld_i[w] && (owner_i[w] != WID) && (excl_i != WID);
  end

  mc_first_one #(.N(WAYS), .IW(WAY_W)) u_empty (
    .vec_i(empty_v), .found_o(e_found), .idx_o(e_idx));
  mc_first_one #(.N(WAYS), .IW(WAY_W)) u_sel (
    .vec_i(sel_v), .found_o(s_found), .idx_o(s_idx));

  assign found_o  = e_found || s_found;
  assign way_o    = e_found ? e_idx : s_idx;
  assign is_sel_o = !e_found && s_found;
endmodule

// File: rtl/mc_cache.sv
module mc_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2,
  parameter int WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_status_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  import mc_pkg::*;

  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  mc_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAYS-1:0]   pend_q;
  logic              resp_valid_q;
  mc_status_e        resp_status_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [SETS-1:0][WAYS-1:0]             vld_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] dat_q;
  logic [SETS-1:0][WAYS-1:0][WAYS-1:0]   vec_q; // [set][home][way]

  logic [SET_W-1:0] set_s;
  logic [TAG_W-1:0] tag_s;
  logic [WAY_W-1:0] home_s;
  assign set_s  = addr_q[SET_W-1:0];
  assign tag_s  = addr_q[ADDR_W-1:SET_W];
  assign home_s = tag_s[WAY_W-1:0];

  logic [WAYS-1:0]            hit_v;
  logic [WAYS-1:0][WAY_W-1:0] owner_v;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_v[w]   = vld_q[set_s][w] && (tag_q[set_s][w] == tag_s);
    assign owner_v[w] = tag_q[set_s][w][WAY_W-1:0];
  end

  logic [WAYS-1:0]  home_vec;
  logic             home_vld;
  logic [WAY_W-1:0] home_owner;
  assign home_vec   = vec_q[set_s][home_s];
  assign home_vld   = vld_q[set_s][home_s];
  assign home_owner = owner_v[home_s];

  logic             scan_found;
  logic [WAY_W-1:0] scan_idx;
  mc_first_one #(.N(WAYS), .IW(WAY_W)) u_scan (
    .vec_i(pend_q), .found_o(scan_found), .idx_o(scan_idx));

  logic             pl_found, pl_is_sel;
  logic [WAY_W-1:0] pl_way;
  mc_place_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_place (
    .vld_i(vld_q[set_s]), .owner_i(owner_v), .excl_i(home_s),
    .found_o(pl_found), .way_o(pl_way), .is_sel_o(pl_is_sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      pend_q        <= '0;
      resp_valid_q  <= 1'b0;
      resp_status_q <= MC_FIRST;
      resp_data_q   <= '0;
      vld_q         <= '0;
      tag_q         <= '0;
      dat_q         <= '0;
      vec_q         <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            addr_q  <= req_addr_i;
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (hit_v[home_s]) begin
            resp_valid_q  <= 1'b1;
            resp_status_q <= MC_FIRST;
            resp_data_q   <= dat_q[set_s][home_s];
            state_q       <= ST_IDLE;
          end else if (|home_vec) begin
            pend_q  <= home_vec;
            state_q <= ST_SCAN;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_SCAN: begin
          if (!scan_found) begin
            state_q <= ST_FILL;
          end else if (hit_v[scan_idx]) begin
            resp_valid_q  <= 1'b1;
            resp_status_q <= MC_NEXT;
            resp_data_q   <= dat_q[set_s][scan_idx];
            // swap: hit block becomes MRU in home, old MRU takes its slot
            tag_q[set_s][home_s]   <= tag_q[set_s][scan_idx];
            dat_q[set_s][home_s]   <= dat_q[set_s][scan_idx];
            tag_q[set_s][scan_idx] <= tag_q[set_s][home_s];
            dat_q[set_s][scan_idx] <= dat_q[set_s][home_s];
            state_q <= ST_IDLE;
          end else begin
            pend_q[scan_idx] <= 1'b0;
          end
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            tag_q[set_s][home_s] <= tag_s;
            dat_q[set_s][home_s] <= mem_data_i;
            vld_q[set_s][home_s] <= 1'b1;
            if (home_vld) begin
              if (home_owner != home_s) begin
                // foreign older block overwritten: drop its link
                vec_q[set_s][home_owner][home_s] <= 1'b0;
              end else if (pl_found) begin
                tag_q[set_s][pl_way] <= tag_q[set_s][home_s];
                dat_q[set_s][pl_way] <= dat_q[set_s][home_s];
                vld_q[set_s][pl_way] <= 1'b1;
                if (pl_is_sel) vec_q[set_s][owner_v[pl_way]][pl_way] <= 1'b0;
                vec_q[set_s][home_s][pl_way] <= 1'b1;
              end
            end
            resp_valid_q  <= 1'b1;
            resp_status_q <= MC_MISS;
            resp_data_q   <= mem_data_i;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign resp_valid_o  = resp_valid_q;
  assign resp_status_o = resp_status_q;
  assign resp_data_o   = resp_data_q;
  assign mem_req_o     = (state_q == ST_FILL);
  assign mem_addr_o    = addr_q;

  logic vec_ok;
  always_comb begin
    vec_ok = 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      if (home_vec[w] && (!vld_q[set_s][w] || owner_v[w] != home_s || w == int'(home_s)))
        vec_ok = 1'b0;
    end
  end

  logic scan_hit, fill_done;
  assign scan_hit  = (state_q == ST_SCAN) && scan_found && hit_v[scan_idx];
  assign fill_done = (state_q == ST_FILL) && mem_ack_i;

  // R7
  vec_links_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROBE) |-> vec_ok);
  // R5
  swap_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_hit |=> hit_v[home_s]);
  // R4
  fill_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> hit_v[home_s]);
  // R9
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R9
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

// File: tb/sim_mc_cache.sv
`timescale 1ns/1ps
module sim_mc_cache;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_data = '0;
  logic req_ready, resp_valid, mem_req;
  logic [1:0] resp_status;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mc_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .resp_valid_o(resp_valid), .resp_status_o(resp_status), .resp_data_o(resp_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data));

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return {20'hC0DE0, a};
  endfunction

  function automatic logic [AW-1:0] mk(int tag, int set);
    return AW'((tag << 2) | set);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int g_lat;
  int g_status;
  logic [DW-1:0] g_data;
  logic [AW-1:0] g_maddr;
  bit g_busy_ok;

  task automatic access(logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 1;
    g_maddr = '0;
    g_busy_ok = !req_ready;
    while (!resp_valid && g_lat < 100) begin
      if (mem_req) begin
        mem_ack  = 1'b1;
        mem_data = mem_val(mem_addr);
        g_maddr  = mem_addr;
      end else begin
        mem_ack = 1'b0;
      end
      @(negedge clk);
      g_lat++;
    end
    mem_ack = 1'b0;
    g_status = int'(resp_status);
    g_data = resp_data;
  endtask

  // lat 0 means latency not checked
  task automatic expect_acc(logic [AW-1:0] a, int st, int lat, string req);
    access(a);
    check(g_status == st, req, "status", g_status, st);
    check(g_data == mem_val(a), req, "data", g_data, mem_val(a));
    if (lat != 0) check(g_lat == lat, req, "latency", g_lat, lat);
    if (st == 2) check(g_maddr == a, req, "mem_addr", g_maddr, a);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
    check(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);
    expect_acc(mk(1, 0), 2, 0, "R1");
    check(g_busy_ok, "R9", "ready low while busy", !g_busy_ok, 0);
    expect_acc(mk(1, 0), 0, 2, "R2");
  endtask

  task automatic t_swap;
    expect_acc(mk(5, 0), 2, 0, "R4");
    expect_acc(mk(1, 0), 1, 3, "R5");
    expect_acc(mk(1, 0), 0, 2, "R3");
    expect_acc(mk(5, 0), 1, 3, "R5");
    expect_acc(mk(5, 0), 0, 2, "R3");
  endtask

  task automatic t_foreign;
    expect_acc(mk(8, 0), 2, 0, "R7");
    expect_acc(mk(1, 0), 2, 0, "R7");
    expect_acc(mk(8, 0), 0, 2, "R7");
    expect_acc(mk(5, 0), 1, 3, "R8");
  endtask

  task automatic t_place;
    expect_acc(mk(11, 0), 2, 0, "R4");
    expect_acc(mk(12, 0), 2, 0, "R8");
    expect_acc(mk(1, 0), 2, 0, "R8");
    expect_acc(mk(8, 0), 2, 0, "R8");
    expect_acc(mk(12, 0), 1, 3, "R8");
    expect_acc(mk(11, 0), 0, 2, "R2");
  endtask

  task automatic t_drop;
    for (int t = 16; t < 20; t++) expect_acc(mk(t, 1), 2, 0, "R1");
    expect_acc(mk(20, 1), 2, 0, "R8");
    expect_acc(mk(16, 1), 2, 0, "R8");
    expect_acc(mk(17, 1), 0, 2, "R8");
    expect_acc(mk(19, 1), 0, 2, "R8");
  endtask

  task automatic t_order;
    expect_acc(mk(0, 2), 2, 0, "R6");
    expect_acc(mk(4, 2), 2, 0, "R6");
    expect_acc(mk(8, 2), 2, 0, "R6");
    expect_acc(mk(4, 2), 1, 4, "R6");
    expect_acc(mk(0, 2), 1, 3, "R6");
    expect_acc(mk(12, 2), 2, 0, "R4");
    expect_acc(mk(0, 2), 1, 0, "R5");
  endtask

  task automatic t_pulse;
    expect_acc(mk(0, 2), 0, 2, "R3");
    @(negedge clk);
    check(resp_valid == 1'b0, "R9", "resp pulse", resp_valid, 0);
    check(req_ready == 1'b1, "R9", "ready idle", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_swap();
    t_foreign();
    t_place();
    t_drop();
    t_order();
    t_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule